// File: doc/BRIEF.md
# Watchdog Timer with Post-Reset Configuration Lock

This block is a retriggerable watchdog for a small processor subsystem. After any reset it sits idle until software issues its first kick, a one-cycle strobe. From then on it counts ticks from one of two timebases, an internal RC tick or an external-clock tick, both supplied as one-cycle enables. Each later kick restarts the count from zero. If the count reaches the selected terminal value before the next kick, the block drives a fixed-length reset request pulse.

The timeout length, the timebase and whether counting continues during halt or stop are held in a write-only mode register. Software can write it only in a short window after power-on reset, after a watchdog reset, or after a stop-mode recovery. Once that window closes, the register is frozen until the next such event. A watchdog reset also returns every mode field to its default value.

The control state machine has three states. IDLE moves to ARMED on a kick. ARMED stays in ARMED on a kick, which clears the count. ARMED moves to FIRE when the terminal count is reached with no kick in that cycle. FIRE holds for the pulse length and then returns to IDLE.

Top module: `wdog_lockcfg`

## Requirements
- R1: After reset, `rst_req_o` is 0. No reset request is ever issued before the first kick, however many ticks arrive.
- R2: A kick while armed clears the count to zero. Kicks spaced closer than the timeout prevent any reset request.
- R3: While armed, the block counts each cycle in which the selected tick is high and counting is allowed. On the edge of the Nth counted tick, where N is the terminal count, the state moves to FIRE. `rst_req_o` is high from that edge onward.
- R4: `rst_req_o` stays high for exactly 4 clock cycles per watchdog event. During the pulse, kicks and writes are ignored, and the block then returns to idle.
- R5: Mode bits 1:0 select N: 00 = 256, 01 = 512, 10 = 1024, 11 = 4096. The reset default is 01.
- R6: Mode bit 2 = 1 keeps counting while `halt_i` is high. Bit 2 = 0 freezes the count during halt. The default is 1.
- R7: Mode bit 3 = 1 keeps counting while `stop_i` is high. Bit 3 = 0 freezes the count during stop. The default is 1.
- R8: Mode bit 4 selects the timebase: 0 = `tick_rc_i` (default), 1 = `tick_ext_i`. The unselected tick has no effect.
- R9: A write is accepted only on the first 60 rising clock edges after reset release, watchdog pulse end or stop recovery. Writes on later edges leave the mode unchanged.
- R10: Writes are decoded at address 0x0F only; other addresses have no effect. Data bits 7:5 are discarded and only bits 4:0 are stored.
- R11: A watchdog event restores all mode fields to their defaults. After the pulse, a new 60-edge write window opens.
- R12: A one-cycle `stop_wake_i` reopens the 60-edge write window and keeps the stored mode.
- R13: A kick in the same cycle as the terminal tick wins: no reset request is issued, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | One-cycle watchdog refresh strobe |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_addr_i | input | 8 | Write address; the mode register is at 0x0F |
| wr_data_i | input | 8 | Write data; bits 4:0 are stored |
| halt_i | input | 1 | Processor is in halt |
| stop_i | input | 1 | Processor is in stop |
| stop_wake_i | input | 1 | One-cycle stop-mode recovery indication |
| tick_rc_i | input | 1 | Internal RC timebase tick enable |
| tick_ext_i | input | 1 | External-clock timebase tick enable |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The two functions that can fall in one cycle are a kick and the terminal tick. The bench provokes this by kicking, counting exactly N-1 ticks, and then raising the next kick in the very cycle that carries the Nth tick. It judges the result by requiring that `rst_req_o` stays low afterwards and that a full new timeout is needed before a request appears. A second collision, a mode write on the 60th and the 61st edge of the window, is run in both variants and judged through the resulting timeout length.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Stored mode fields; packed order matches written data bits 4:0.
    typedef struct packed {
        logic       src_ext;   // bit 4
        logic       stop_run;  // bit 3
        logic       halt_run;  // bit 2
        logic [1:0] tap;       // bits 1:0
    } wdog_cfg_t;

    localparam wdog_cfg_t CFG_DEFAULT = '{
        src_ext:  1'b0,
        stop_run: 1'b1,
        halt_run: 1'b1,
        tap:      2'b01
    };

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } wdog_state_t;

endpackage

// File: rtl/wdog_cfg_win.sv
module wdog_cfg_win
    import wdog_pkg::*;
#(
    parameter int             ADDR_W     = 8,
    parameter int             DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h0F,
    parameter int             WIN_CYCLES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wake_i,
    input  logic              fire_i,
    input  logic              hold_i,
    output wdog_cfg_t         cfg_o,
    output logic              win_open_o
);

    localparam int WIN_W  = $clog2(WIN_CYCLES + 1);
    localparam int CFG_W  = $bits(wdog_cfg_t);

    logic [WIN_W-1:0] win_cnt;
    logic             wr_hit;

    assign win_open_o = (win_cnt < WIN_W'(WIN_CYCLES)) && !hold_i;
    assign wr_hit     = wr_en_i && (wr_addr_i == CFG_ADDR) && win_open_o;

    // Window counter: restarts on watchdog event, while the pulse is out,
    // and on stop-mode recovery; saturates at the window length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (fire_i || hold_i || wake_i) begin
            win_cnt <= '0;
        end else if (win_cnt < WIN_W'(WIN_CYCLES)) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // Mode register: watchdog event wins over a write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o <= CFG_DEFAULT;
        end else if (fire_i) begin
            cfg_o <= CFG_DEFAULT;
        end else if (wr_hit) begin
            cfg_o <= wdog_cfg_t'(wr_data_i[CFG_W-1:0]);
        end
    end

    assert_locked_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open_o && !fire_i) |=> $stable(cfg_o));

    assert_defaults_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (cfg_o == CFG_DEFAULT));

    assert_rsvd_dropped_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !fire_i && (|wr_data_i[DATA_W-1:CFG_W]))
            |=> (cfg_o == wdog_cfg_t'($past(wr_data_i[CFG_W-1:0]))));

endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
    import wdog_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int TAP0  = 256,
    parameter int TAP1  = 512,
    parameter int TAP2  = 1024,
    parameter int TAP3  = 4096
) (
    input  wdog_cfg_t        cfg_i,
    input  logic             tick_rc_i,
    input  logic             tick_ext_i,
    input  logic             halt_i,
    input  logic             stop_i,
    output logic             cnt_en_o,
    output logic [CNT_W-1:0] term_m1_o
);

    localparam int NTAPS = 4;
    localparam int TAPS [NTAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [CNT_W-1:0] term_tbl [NTAPS];
    logic             tick_sel;
    logic             run_ok;

    for (genvar g = 0; g < NTAPS; g++) begin : g_term
        assign term_tbl[g] = CNT_W'(TAPS[g] - 1);
    end

    assign term_m1_o = term_tbl[cfg_i.tap];
    assign tick_sel  = cfg_i.src_ext ? tick_ext_i : tick_rc_i;
    assign run_ok    = !(halt_i && !cfg_i.halt_run) && !(stop_i && !cfg_i.stop_run);
    assign cnt_en_o  = tick_sel && run_ok;

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 13,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_i,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] term_m1_i,
    output logic             fire_o,
    output logic             hold_o,
    output logic             rst_req_o
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    wdog_state_t      state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [PW-1:0]    pcnt;

    assign fire_o = (state == ST_ARMED) && !kick_i && cnt_en_i && (cnt >= term_m1_i);
    assign hold_o = (state == ST_FIRE);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (kick_i) state_nxt = ST_ARMED;
            ST_ARMED: if (fire_o) state_nxt = ST_FIRE;
            ST_FIRE:  if (pcnt == PW'(PULSE_LEN - 1)) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Timeout and pulse counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else begin
            unique case (state)
                ST_ARMED: begin
                    if (kick_i || fire_o) cnt <= '0;
                    else if (cnt_en_i)    cnt <= cnt + 1'b1;
                end
                default: cnt <= '0;
            endcase
            pcnt <= (state == ST_FIRE) ? pcnt + 1'b1 : '0;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req_o <= 1'b0;
        else        rst_req_o <= (state_nxt == ST_FIRE);
    end

    assert_idle_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !rst_req_o);

    assert_fire_out_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> rst_req_o);

    assert_pulse_min_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |=> rst_req_o);

    assert_hold_count_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !kick_i && !cnt_en_i) |=> $stable(cnt));

    assert_kick_wins_R13 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && kick_i) |=> (!rst_req_o && cnt == '0));

endmodule

// File: rtl/wdog_lockcfg.sv
module wdog_lockcfg
    import wdog_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h0F,
    parameter int                WIN_CYCLES = 60,
    parameter int                PULSE_LEN  = 4,
    parameter int                TAP0       = 256,
    parameter int                TAP1       = 512,
    parameter int                TAP2       = 1024,
    parameter int                TAP3       = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              halt_i,
    input  logic              stop_i,
    input  logic              stop_wake_i,
    input  logic              tick_rc_i,
    input  logic              tick_ext_i,
    output logic              rst_req_o
);

    localparam int MAX01 = (TAP0 > TAP1) ? TAP0 : TAP1;
    localparam int MAX23 = (TAP2 > TAP3) ? TAP2 : TAP3;
    localparam int TMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(TMAX + 1);

    wdog_cfg_t        cfg;
    logic             win_open;
    logic             cnt_en;
    logic [CNT_W-1:0] term_m1;
    logic             fire;
    logic             hold;

    wdog_cfg_win #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (8),
        .CFG_ADDR   (CFG_ADDR),
        .WIN_CYCLES (WIN_CYCLES)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .wake_i     (stop_wake_i),
        .fire_i     (fire),
        .hold_i     (hold),
        .cfg_o      (cfg),
        .win_open_o (win_open)
    );

    wdog_tick_sel #(
        .CNT_W (CNT_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) u_tick (
        .cfg_i      (cfg),
        .tick_rc_i  (tick_rc_i),
        .tick_ext_i (tick_ext_i),
        .halt_i     (halt_i),
        .stop_i     (stop_i),
        .cnt_en_o   (cnt_en),
        .term_m1_o  (term_m1)
    );

    wdog_fsm #(
        .CNT_W     (CNT_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_i    (kick_i),
        .cnt_en_i  (cnt_en),
        .term_m1_i (term_m1),
        .fire_o    (fire),
        .hold_o    (hold),
        .rst_req_o (rst_req_o)
    );

    assert_no_write_in_pulse_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !win_open);

endmodule

// File: tb/wdog_lockcfg_bench.sv
module wdog_lockcfg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 4;
    localparam int WIN        = 60;
    localparam int DEF_CFG    = 5'b01101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kick = 1'b0, wr_en = 1'b0, halt = 1'b0, stop = 1'b0, wake = 1'b0;
    logic       tick_rc = 1'b0, tick_ext = 1'b0;
    logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
    logic       rst_req;

    int    n_run = 0, n_fail = 0, n_rise = 0, cyc = 0;
    string cur_req = "R1";
    bit    rc_on = 1'b1;
    int    ext_div = 0;

    // Reference model state
    bit m_armed = 1'b0;
    int m_cnt = 0, m_fl = 0, m_cfg = DEF_CFG, m_win = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_lockcfg u_wdog_lockcfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick_i      (kick),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .halt_i      (halt),
        .stop_i      (stop),
        .stop_wake_i (wake),
        .tick_rc_i   (tick_rc),
        .tick_ext_i  (tick_ext),
        .rst_req_o   (rst_req)
    );

    function automatic int term_of(int t);
        case (t & 3)
            0: return 256;
            1: return 512;
            2: return 1024;
            default: return 4096;
        endcase
    endfunction

    // Behavioural reference, one step per rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_armed = 1'b0; m_cnt = 0; m_fl = 0; m_cfg = DEF_CFG; m_win = 0;
        end else if (m_fl > 0) begin
            m_fl--;
            m_win = 0;
        end else begin
            bit tsel, run, fire, wok;
            int nwin;
            fire = 1'b0;
            tsel = ((m_cfg >> 4) & 1) != 0 ? tick_ext : tick_rc;
            run  = !(halt && ((m_cfg >> 2) & 1) == 0) && !(stop && ((m_cfg >> 3) & 1) == 0);
            wok  = wr_en && (wr_addr == 8'h0F) && (m_win < WIN);
            nwin = wake ? 0 : ((m_win < WIN) ? m_win + 1 : m_win);
            if (!m_armed) begin
                if (kick) begin m_armed = 1'b1; m_cnt = 0; end
            end else if (kick) begin
                m_cnt = 0;
            end else if (tsel && run) begin
                if (m_cnt + 1 >= term_of(m_cfg)) fire = 1'b1;
                else m_cnt++;
            end
            if (fire) begin
                m_fl = PULSE; m_armed = 1'b0; m_cnt = 0; m_cfg = DEF_CFG; m_win = 0;
            end else begin
                m_win = nwin;
                if (wok) m_cfg = int'(wr_data) & 'h1F;
            end
        end
    end

    // Tick generator and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        tick_rc  = rc_on;
        tick_ext = (ext_div > 0) && (cyc % ext_div == 0);
        n_run++;
        if (rst_req !== (m_fl > 0)) begin
            n_fail++;
            $display("FAIL %s cycle %0d: rst_req_o=%0b expected %0b", cur_req, cyc, rst_req, (m_fl > 0));
        end
    end

    always @(posedge rst_req) n_rise++;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        kick = 0; wr_en = 0; halt = 0; stop = 0; wake = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic kick_once();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic write_reg(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Kick, count cycles to the request, then measure the pulse width
    task automatic measure(int exp_lo, int exp_hi, string req);
        int n = 0, h = 0;
        kick_once();
        while (!rst_req && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n >= exp_lo && n <= exp_hi, req, "timeout cycles", n, exp_lo);
        while (rst_req && h < 100) begin
            @(negedge clk);
            h++;
        end
        check(h == PULSE, "R4", "pulse width", h, PULSE);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_run++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int r0;
        // R1: quiet after reset and before any kick
        cur_req = "R1";
        do_reset();
        check(rst_req == 1'b0, "R1", "reset value", rst_req, 0);
        repeat (5000) @(negedge clk);
        check(n_rise == 0, "R1", "requests before kick", n_rise, 0);

        // R3/R5: default tap 512; R4 pulse
        cur_req = "R5";
        measure(512, 512, "R5");

        // R11: window reopened after the event, tap 00 accepted
        cur_req = "R11";
        write_reg(8'h0F, 8'h00);
        measure(256, 256, "R11");
        // defaults restored after event
        measure(512, 512, "R11");

        // R10: reserved bits dropped, tap 10
        cur_req = "R10";
        do_reset();
        write_reg(8'h0F, 8'hE2);
        measure(1024, 1024, "R10");
        // R10: wrong address ignored
        do_reset();
        write_reg(8'h0E, 8'h00);
        measure(512, 512, "R10");

        // R9: last edge in window accepted, first after rejected
        cur_req = "R9";
        do_reset();
        repeat (59) @(negedge clk);
        write_reg(8'h0F, 8'h0F);
        measure(4096, 4096, "R9");
        do_reset();
        repeat (60) @(negedge clk);
        write_reg(8'h0F, 8'h0C);
        measure(512, 512, "R9");

        // R12: stop recovery reopens the window
        cur_req = "R12";
        do_reset();
        repeat (100) @(negedge clk);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        write_reg(8'h0F, 8'h0C);
        measure(256, 256, "R12");

        // R6: halt freezes with bit 2 = 0
        cur_req = "R6";
        do_reset();
        write_reg(8'h0F, 8'h09);
        halt = 1'b1;
        r0 = n_rise;
        kick_once();
        repeat (1500) @(negedge clk);
        check(n_rise == r0, "R6", "requests while halted", n_rise - r0, 0);
        halt = 1'b0;
        repeat (600) @(negedge clk);
        check(n_rise == r0 + 1, "R6", "requests after halt", n_rise - r0, 1);
        do_reset();
        halt = 1'b1;
        measure(512, 512, "R6");
        halt = 1'b0;

        // R7: stop freezes with bit 3 = 0
        cur_req = "R7";
        do_reset();
        write_reg(8'h0F, 8'h05);
        stop = 1'b1;
        r0 = n_rise;
        kick_once();
        repeat (1500) @(negedge clk);
        check(n_rise == r0, "R7", "requests while stopped", n_rise - r0, 0);
        stop = 1'b0;
        do_reset();
        stop = 1'b1;
        measure(512, 512, "R7");
        stop = 1'b0;

        // R8: timebase select
        cur_req = "R8";
        do_reset();
        rc_on = 1'b0; ext_div = 1;
        r0 = n_rise;
        kick_once();
        repeat (1500) @(negedge clk);
        check(n_rise == r0, "R8", "ext ticks with rc selected", n_rise - r0, 0);
        do_reset();
        rc_on = 1'b1; ext_div = 2;
        write_reg(8'h0F, 8'h1D);
        measure(1022, 1026, "R8");
        ext_div = 0;

        // R2: regular kicks hold off the request
        cur_req = "R2";
        do_reset();
        r0 = n_rise;
        kick_once();
        for (int i = 0; i < 6; i++) begin
            repeat (400) @(negedge clk);
            kick_once();
        end
        check(n_rise == r0, "R2", "requests with kicks", n_rise - r0, 0);

        // R13: kick on the terminal tick
        cur_req = "R13";
        do_reset();
        r0 = n_rise;
        kick_once();
        repeat (511) @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        repeat (8) @(negedge clk);
        check(n_rise == r0, "R13", "request on collision", n_rise - r0, 0);
        repeat (495) @(negedge clk);
        check(n_rise == r0, "R13", "early request after collision", n_rise - r0, 0);
        repeat (20) @(negedge clk);
        check(n_rise == r0 + 1, "R3", "request after full timeout", n_rise - r0, 1);

        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule